// File: doc/BRIEF.md
# Byte-wide host register port for a video memory controller

This block sits between a host processor's 8-bit bus and the video side of a display controller. The host picks one of eight byte registers with a 3-bit select and moves one byte per access. Some registers set the display: a default attribute byte, a mode byte whose lowest bit chooses between a 1bpp bitmap and text, and a 16-bit scroll offset that the display fetch adds to its frame start. The other registers give access to video memory through a 16-bit pointer that the host loads one byte at a time.

Each access to the data register becomes a single request on a request/acknowledge port towards the video memory arbiter. The pointer then moves forward by one, so the host can stream bytes without reloading it. Reads are prefetched. A data read returns at once the byte that the previous read fetched, and then fetches the byte at the pointer for next time. A read sequence after a pointer load therefore lags by one access, and its first result is stale. While a memory request is outstanding the host side deasserts ready, and any further access waits.

Top module: `vreg_host_port`

## Requirements
- R1: After reset the pointer, scroll offset, attribute, mode byte, prefetch buffer and `bus_rdata` are all zero, `mem_req` is low and `bus_ready` is high.
- R2: An access is accepted on a clock edge where `bus_valid` and `bus_ready` are both high. An accepted write to select 0 raises `mem_req` on the next cycle with `mem_we`=1, `mem_addr` equal to the pointer and `mem_wdata` equal to the written byte. Request, address, direction and data stay unchanged until a cycle in which `mem_ack` is high.
- R3: `bus_ready` is low in every cycle in which `mem_req` is high, so a second access waits for the acknowledge. `mem_req` drops in the cycle after the acknowledge.
- R4: An accepted read of select 0 places the prefetch buffer on `bus_rdata` in the next cycle. It also issues a read request (`mem_we`=0) at the pointer, and on acknowledge the buffer captures `mem_rdata`. A read after a pointer load returns the byte fetched by the previous read, and the first read after reset returns 0.
- R5: The pointer advances by one when each data request is acknowledged, and wraps from 0xFFFF to 0x0000.
- R6: Writes to select 4 and select 5 replace the high and low pointer bytes. The new value is used by the next data access.
- R7: A write to select 6 stages the high offset byte and leaves `scroll_offset` unchanged. A write to select 7 updates `scroll_offset` as a whole to {staged high, written low}. No other access changes `scroll_offset`.
- R8: A write to select 1 sets `dflt_attr`. A write to select 2 stores the mode byte, and its bit 0 drives `bitmap_en` (1 = bitmap, 0 = text). A write to select 3 changes no output.
- R9: A read of selects 1 to 7 sets `bus_rdata` to 0 in the next cycle and issues no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host access request |
| bus_ready | output | 1 | High when an access can be accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after acceptance |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request direction, 1 = write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Arbiter acknowledge, one cycle per request |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| scroll_offset | output | 16 | Display start offset |
| dflt_attr | output | 8 | Default attribute byte |
| bitmap_en | output | 1 | 1 selects bitmap mode |

## Verification
The assertions take three things for granted about the arbiter and the host. The arbiter raises `mem_ack` for exactly one cycle, and only while `mem_req` is high. It presents `mem_rdata` in that same cycle. The host treats `bus_valid` as a plain request whose effect is defined only on a ready edge. The bench's arbiter model answers after a latency that cycles through 0, 1 and 2 waits, and it drops the acknowledge as soon as the request falls. The host tasks keep the request, select and data steady until acceptance, so back-to-back and stalled accesses are exercised without leaving these limits.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  typedef enum logic [2:0] {
    SEL_DATA   = 3'd0,
    SEL_ATTR   = 3'd1,
    SEL_MODE   = 3'd2,
    SEL_SPARE  = 3'd3,
    SEL_PTR_HI = 3'd4,
    SEL_PTR_LO = 3'd5,
    SEL_OFS_HI = 3'd6,
    SEL_OFS_LO = 3'd7
  } reg_sel_e;

  localparam int NUM_SEL = 8;
endpackage

// File: rtl/vrp_decode.sv
module vrp_decode
  import vrp_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic                 fire,
  input  logic                 we,
  input  logic [SEL_W-1:0]     sel,
  output logic [NUM_SEL-1:0]   wr_strobe,
  output logic                 data_fire,
  output logic                 cfg_read
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_strobe
    assign wr_strobe[i] = fire && we && (sel == SEL_W'(i));
  end

  assign data_fire = fire && (sel == SEL_W'(SEL_DATA));
  assign cfg_read  = fire && !we && (sel != SEL_W'(SEL_DATA));
endmodule

// File: rtl/vrp_cfg_regs.sv
module vrp_cfg_regs #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              attr_we,
  input  logic              mode_we,
  input  logic              ofs_hi_we,
  input  logic              ofs_lo_we,
  input  logic [DATA_W-1:0] wbyte,
  output logic [DATA_W-1:0] attr,
  output logic              bitmap,
  output logic [OFS_W-1:0]  offset
);
  localparam int HI_W = OFS_W - DATA_W;

  logic [DATA_W-1:0] mode_q;
  logic [HI_W-1:0]   ofs_stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr        <= '0;
      mode_q      <= '0;
      ofs_stage_q <= '0;
      offset      <= '0;
    end else begin
      if (attr_we)   attr        <= wbyte;
      if (mode_we)   mode_q      <= wbyte;
      if (ofs_hi_we) ofs_stage_q <= wbyte[HI_W-1:0];
      if (ofs_lo_we) offset      <= {ofs_stage_q, wbyte};
    end
  end

  assign bitmap = mode_q[0];
endmodule

// File: rtl/vrp_mem_agent.sv
module vrp_mem_agent #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_fire,
  input  logic              acc_we,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              cfg_read,
  input  logic              ptr_hi_we,
  input  logic              ptr_lo_we,
  output logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int HI_W = PTR_W - DATA_W;

  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] prefetch_q;
  logic              done;

  assign done = mem_req && mem_ack;
  assign busy = mem_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      prefetch_q <= '0;
      rdata      <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      if (done) begin
        mem_req <= 1'b0;
        ptr_q   <= ptr_q + 1'b1;
        if (!mem_we) prefetch_q <= mem_rdata;
      end else if (acc_fire) begin
        mem_req  <= 1'b1;
        mem_we   <= acc_we;
        mem_addr <= ptr_q;
        if (acc_we) mem_wdata <= acc_wdata;
        else        rdata     <= prefetch_q;
      end
      if (cfg_read)  rdata             <= '0;
      if (ptr_hi_we) ptr_q[PTR_W-1:DATA_W] <= acc_wdata[HI_W-1:0];
      if (ptr_lo_we) ptr_q[DATA_W-1:0]     <= acc_wdata;
    end
  end
endmodule

// File: rtl/vreg_host_port.sv
module vreg_host_port
  import vrp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 16,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_we,
  input  logic [SEL_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [PTR_W-1:0]  scroll_offset,
  output logic [DATA_W-1:0] dflt_attr,
  output logic              bitmap_en
);
  logic               busy;
  logic               fire;
  logic [NUM_SEL-1:0] wr_strobe;
  logic               data_fire;
  logic               cfg_read;

  assign bus_ready = !busy;
  assign fire      = bus_valid && bus_ready;

  vrp_decode #(.SEL_W(SEL_W)) u_decode (
    .fire      (fire),
    .we        (bus_we),
    .sel       (bus_addr),
    .wr_strobe (wr_strobe),
    .data_fire (data_fire),
    .cfg_read  (cfg_read)
  );

  vrp_cfg_regs #(.DATA_W(DATA_W), .OFS_W(PTR_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .attr_we   (wr_strobe[SEL_ATTR]),
    .mode_we   (wr_strobe[SEL_MODE]),
    .ofs_hi_we (wr_strobe[SEL_OFS_HI]),
    .ofs_lo_we (wr_strobe[SEL_OFS_LO]),
    .wbyte     (bus_wdata),
    .attr      (dflt_attr),
    .bitmap    (bitmap_en),
    .offset    (scroll_offset)
  );

  vrp_mem_agent #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_fire  (data_fire),
    .acc_we    (bus_we),
    .acc_wdata (bus_wdata),
    .cfg_read  (cfg_read),
    .ptr_hi_we (wr_strobe[SEL_PTR_HI]),
    .ptr_lo_we (wr_strobe[SEL_PTR_LO]),
    .busy      (busy),
    .rdata     (bus_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
  );
endmodule

// File: rtl/vrp_checker.sv
module vrp_checker #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 16,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_we,
  input logic [SEL_W-1:0]  bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [PTR_W-1:0]  mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [PTR_W-1:0]  scroll_offset,
  input logic [DATA_W-1:0] dflt_attr,
  input logic              bitmap_en
);
  logic acc;
  assign acc = bus_valid && bus_ready;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R2

  AST_REQ_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(acc && bus_addr == '0)); // R2

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !bus_ready); // R3

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req); // R3

  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && bus_we && bus_addr == SEL_W'(7)) |=> $stable(scroll_offset)); // R7

  AST_CFG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !bus_we && bus_addr != '0 |=> bus_rdata == '0); // R9
endmodule

bind vreg_host_port vrp_checker #(.DATA_W(DATA_W), .PTR_W(PTR_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_vreg_host_port.sv
module tb_vreg_host_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'hEE;
  logic [15:0] scroll_offset;
  logic [7:0]  dflt_attr;
  logic        bitmap_en;

  int compared = 0;
  int mismatched = 0;
  bit model_on = 1'b0;

  always #10 clk = ~clk;

  vreg_host_port dut (.*);

  // behavioural arbiter and memory
  logic [7:0] vmem [int];
  int lat = 0;
  int waited = 0;

  // reference model state
  int m_ptr = 0, m_buf = 0, m_rd = 0, m_attr = 0, m_mode = 0;
  int m_stage = 0, m_ofs = 0, m_addr = 0, m_wdata = 0;
  bit m_req = 0, m_we = 0;

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (model_on) begin
      if (m_req) begin
        if (mem_ack) begin
          m_req = 0;
          if (!m_we) m_buf = mem_rdata;
          m_ptr = (m_ptr + 1) % 65536;
        end
      end else if (bus_valid) begin
        if (bus_addr == 0) begin
          m_req = 1; m_we = bus_we; m_addr = m_ptr;
          if (bus_we) m_wdata = bus_wdata; else m_rd = m_buf;
        end else if (!bus_we) m_rd = 0;
        else case (bus_addr)
          1: m_attr = bus_wdata;
          2: m_mode = bus_wdata;
          4: m_ptr = (m_ptr % 256) + 256 * bus_wdata;
          5: m_ptr = (m_ptr / 256) * 256 + bus_wdata;
          6: m_stage = bus_wdata;
          7: m_ofs = m_stage * 256 + bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R3 bus_ready", bus_ready, !m_req);
      check("R2 mem_req", mem_req, m_req);
      if (m_req) begin
        check("R2 mem_we", mem_we, m_we);
        check("R5 mem_addr", mem_addr, m_addr);
        if (m_we) check("R2 mem_wdata", mem_wdata, m_wdata);
      end
      check("R4 bus_rdata", bus_rdata, m_rd);
      check("R7 scroll_offset", scroll_offset, m_ofs);
      check("R8 dflt_attr", dflt_attr, m_attr);
      check("R8 bitmap_en", bitmap_en, m_mode % 2);
    end
    // arbiter: acknowledge after lat waiting cycles
    if (mem_req && rst_n) begin
      if (waited == lat) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          vmem[int'(mem_addr)] = mem_wdata;
          mem_rdata = 8'hEE;
        end else mem_rdata = vmem.exists(int'(mem_addr)) ? vmem[int'(mem_addr)] : 8'h00;
        waited = 0;
        lat = (lat + 1) % 3;
      end else begin
        mem_ack = 1'b0;
        mem_rdata = 8'hEE;
        waited++;
      end
    end else begin
      mem_ack = 1'b0;
      mem_rdata = 8'hEE;
    end
  end

  task automatic access(input bit we, input int sel, input int data, output int rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = 3'(sel); bus_wdata = 8'(data);
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    rd = bus_rdata;
  endtask

  task automatic wr(input int sel, input int data);
    int unused;
    access(1'b1, sel, data, unused);
  endtask

  task automatic set_ptr(input int p);
    wr(4, p / 256);
    wr(5, p % 256);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    int rd;
    int pat [8];
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 bus_ready", bus_ready, 1);
    check("R1 mem_req", mem_req, 0);
    check("R1 scroll_offset", scroll_offset, 0);
    check("R1 dflt_attr", dflt_attr, 0);
    check("R1 bitmap_en", bitmap_en, 0);
    check("R1 bus_rdata", bus_rdata, 0);
    model_on = 1'b1;

    // R1/R4 first read after reset returns the reset buffer
    access(1'b0, 0, 0, rd);
    check("R4 first read", rd, 0);

    // R2 R6 write pattern, reload pointer, R4 shifted read back
    set_ptr(16'h1234);
    for (int i = 0; i < 8; i++) begin
      pat[i] = (i * 37 + 11) % 256;
      wr(0, pat[i]);
    end
    set_ptr(16'h1234);
    access(1'b0, 0, 0, rd);
    check("R4 stale first read", rd, 0);
    for (int i = 0; i < 8; i++) begin
      access(1'b0, 0, 0, rd);
      check("R4 shifted read", rd, pat[i]);
    end

    // R5 wrap
    set_ptr(16'hFFFF);
    wr(0, 8'hA5);
    wr(0, 8'h5A);
    set_ptr(16'hFFFF);
    access(1'b0, 0, 0, rd);
    access(1'b0, 0, 0, rd);
    check("R5 read at FFFF", rd, 8'hA5);
    access(1'b0, 0, 0, rd);
    check("R5 wrap to 0000", rd, 8'h5A);

    // R7 offset staging
    wr(6, 8'hAB);
    check("R7 hi alone", scroll_offset, 0);
    wr(7, 8'hCD);
    check("R7 whole update", scroll_offset, 16'hABCD);

    // R8 attribute, mode, spare
    wr(1, 8'h3C);
    check("R8 attr", dflt_attr, 8'h3C);
    wr(2, 8'h01);
    check("R8 bitmap on", bitmap_en, 1);
    wr(3, 8'hFF);
    check("R8 spare ignored", {dflt_attr, bitmap_en, scroll_offset}, {8'h3C, 1'b1, 16'hABCD});
    wr(2, 8'hFE);
    check("R8 text mode", bitmap_en, 0);

    // R9 non-data reads return zero, no request
    for (int s = 1; s < 8; s++) begin
      access(1'b0, s, 0, rd);
      check("R9 cfg read zero", rd, 0);
      check("R9 no request", mem_req, 0);
    end

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule